// File: doc/BRIEF.md
# Condition Code Evaluator with Select and Set Outputs

This block reduces a 4-bit condition code and the four processor flags (zero, negative, overflow, carry) to a single true/false decision. The same decision is used in three ways. It is the taken/not-taken indication for a conditional branch. It picks between two data operands for a select operation. It also forms a 0/1 data word for a set-on-condition instruction.

The condition code has two parts. The upper three bits choose a base test. The lowest bit, when set, inverts that test, so every even code has its complement at the next odd code. The inputs are sampled on each rising clock edge, and all three outputs are registered. Each output therefore reflects the inputs from the edge before. A synchronous active-high reset clears the outputs.

Top module: `cc_eval_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `cond_true`, `sel_out` and `bool_word` are all zero after that edge.
- R2: Outputs change only at a rising edge and show the inputs sampled at that edge; input changes between edges have no effect on the outputs until the next edge.
- R3: For every even code k and every flag combination, code k+1 (bit 0 set) gives the logical complement of code k.
- R4: Code 4'b0000 is always true and code 4'b0001 is always false, whatever the flags.
- R5: Code 4'b0010 is C and not Z; code 4'b0011 is not C or Z.
- R6: Code 4'b0100 is not C and code 4'b0101 is C; code 4'b0110 is not Z and code 4'b0111 is Z.
- R7: Code 4'b1000 is not V and code 4'b1001 is V; code 4'b1010 is not N and code 4'b1011 is N.
- R8: Code 4'b1100 is N xnor V; code 4'b1101 is N xor V.
- R9: Code 4'b1110 is not Z and (N xnor V); code 4'b1111 is Z or (N xor V).
- R10: `sel_out` equals `src_a` when the condition holds and `src_b` otherwise.
- R11: `bool_word` is 1 (zero-extended to DATA_W bits) when the condition holds and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cond_code | input | 4 | Bits 3:1 select the base test, bit 0 inverts it |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| src_a | input | DATA_W | Operand returned when the condition holds |
| src_b | input | DATA_W | Operand returned when the condition fails |
| cond_true | output | 1 | Registered condition result (branch taken) |
| sel_out | output | DATA_W | Registered select result |
| bool_word | output | DATA_W | Registered 0/1 word for set-on-condition |

## Verification
The assertions assume that every input is a known value at each rising edge while reset is low. They also assume that reset is asserted at the first edge, so that each property only compares an output with inputs sampled one edge earlier under normal operation. The bench holds reset high from time zero. It changes inputs only at falling edges and always drives defined values, including the full sweep of all sixteen codes against all sixteen flag combinations.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CODE_W = 4;
  localparam int BASE_W = CODE_W - 1;
  localparam int NUM_BASE = 1 << BASE_W;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
  } flags_t;

  typedef enum logic [BASE_W-1:0] {
    BASE_ALWAYS = 3'd0,
    BASE_HI     = 3'd1,
    BASE_NOCAR  = 3'd2,
    BASE_NONZ   = 3'd3,
    BASE_NOOVF  = 3'd4,
    BASE_POS    = 3'd5,
    BASE_GE     = 3'd6,
    BASE_GT     = 3'd7
  } base_sel_t;
endpackage

// File: rtl/cc_base_tests.sv
module cc_base_tests
  import cc_pkg::*;
(
  input  flags_t              flags,
  output logic [NUM_BASE-1:0] tests
);
  logic sign_ok;

  always_comb begin
    sign_ok = ~(flags.n ^ flags.v);
    tests = '0;
    tests[BASE_ALWAYS] = 1'b1;
    tests[BASE_HI]     = flags.c & ~flags.z;
    tests[BASE_NOCAR]  = ~flags.c;
    tests[BASE_NONZ]   = ~flags.z;
    tests[BASE_NOOVF]  = ~flags.v;
    tests[BASE_POS]    = ~flags.n;
    tests[BASE_GE]     = sign_ok;
    tests[BASE_GT]     = sign_ok & ~flags.z;
  end
endmodule

// File: rtl/cc_cond_pick.sv
module cc_cond_pick
  import cc_pkg::*;
(
  input  logic [CODE_W-1:0]   code,
  input  logic [NUM_BASE-1:0] tests,
  output logic                result
);
  logic [BASE_W-1:0] sel;
  logic              inv;

  always_comb begin
    sel    = code[CODE_W-1:1];
    inv    = code[0];
    result = tests[sel] ^ inv;
  end
endmodule

// File: rtl/cc_word_out.sv
module cc_word_out #(
  parameter int DATA_W = 32
) (
  input  logic              hit,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sel_word,
  output logic [DATA_W-1:0] flag_word
);
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_bit
      assign sel_word[gi] = hit ? a[gi] : b[gi];
      if (gi == 0) begin : g_lsb
        assign flag_word[gi] = hit;
      end else begin : g_upper
        assign flag_word[gi] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/cc_eval_unit.sv
module cc_eval_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cond_code,
  input  logic              flag_z,
  input  logic              flag_n,
  input  logic              flag_v,
  input  logic              flag_c,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              cond_true,
  output logic [DATA_W-1:0] sel_out,
  output logic [DATA_W-1:0] bool_word
);
  import cc_pkg::*;

  flags_t              flags;
  logic [NUM_BASE-1:0] tests;
  logic                hit;
  logic [DATA_W-1:0]   sel_d;
  logic [DATA_W-1:0]   bool_d;

  assign flags = '{z: flag_z, n: flag_n, v: flag_v, c: flag_c};

  cc_base_tests u_tests (
    .flags (flags),
    .tests (tests)
  );

  cc_cond_pick u_pick (
    .code   (cond_code),
    .tests  (tests),
    .result (hit)
  );

  cc_word_out #(.DATA_W(DATA_W)) u_word (
    .hit       (hit),
    .a         (src_a),
    .b         (src_b),
    .sel_word  (sel_d),
    .flag_word (bool_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_true <= 1'b0;
      sel_out   <= '0;
      bool_word <= '0;
    end else begin
      cond_true <= hit;
      sel_out   <= sel_d;
      bool_word <= bool_d;
    end
  end
endmodule

// File: rtl/cc_eval_unit_chk.sv
module cc_eval_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        cond_code,
  input logic              flag_z,
  input logic              flag_n,
  input logic              flag_v,
  input logic              flag_c,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              cond_true,
  input logic [DATA_W-1:0] sel_out,
  input logic [DATA_W-1:0] bool_word
);
  p_select_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sel_out == (cond_true ? $past(src_a) : $past(src_b)));

  p_bool_word_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(bool_word) == int'(cond_true)) && (bool_word[0] == cond_true));

  p_always_r4: assert property (@(posedge clk) disable iff (rst)
    cond_code == 4'b0000 |=> cond_true);

  p_never_r4: assert property (@(posedge clk) disable iff (rst)
    cond_code == 4'b0001 |=> !cond_true);

  p_equal_r6: assert property (@(posedge clk) disable iff (rst)
    cond_code == 4'b0111 |=> cond_true == $past(flag_z));

  p_carry_r6: assert property (@(posedge clk) disable iff (rst)
    cond_code == 4'b0101 |=> cond_true == $past(flag_c));

  p_less_r8: assert property (@(posedge clk) disable iff (rst)
    cond_code == 4'b1101 |=> cond_true == ($past(flag_n) ^ $past(flag_v)));

  p_greater_r9: assert property (@(posedge clk) disable iff (rst)
    cond_code == 4'b1110 |=>
      cond_true == (!$past(flag_z) && ($past(flag_n) == $past(flag_v))));
endmodule

bind cc_eval_unit cc_eval_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_cc_eval_unit.sv
module tb_cc_eval_unit;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [3:0]        cond_code = 4'd0;
  logic              flag_z = 1'b0, flag_n = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
  logic [DATA_W-1:0] src_a = '0, src_b = '0;
  logic              cond_true;
  logic [DATA_W-1:0] sel_out, bool_word;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  cc_eval_unit #(.DATA_W(DATA_W)) dut (.*);

  function automatic bit expect_cond(input logic [3:0] k, input logic z, n, v, c);
    case (k)
      4'b0000: return 1'b1;
      4'b0001: return 1'b0;
      4'b0010: return c && !z;
      4'b0011: return !c || z;
      4'b0100: return !c;
      4'b0101: return c;
      4'b0110: return !z;
      4'b0111: return z;
      4'b1000: return !v;
      4'b1001: return v;
      4'b1010: return !n;
      4'b1011: return n;
      4'b1100: return n == v;
      4'b1101: return n != v;
      4'b1110: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] k);
    case (k[3:1])
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2, 3'd3: return "R6";
      3'd4, 3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] k, input logic [3:0] f,
                       input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    @(negedge clk);
    cond_code = k;
    {flag_z, flag_n, flag_v, flag_c} = f;
    src_a = a;
    src_b = b;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset_r1();
    @(negedge clk);
    rst = 1'b1;
    cond_code = 4'b0000;
    src_a = 32'hFFFF_FFFF;
    @(posedge clk);
    #1;
    check(cond_true == 1'b0, "R1 cond", {31'd0, cond_true}, 0);
    check(sel_out == '0, "R1 sel", sel_out, 0);
    check(bool_word == '0, "R1 bool", bool_word, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 16; k++) begin
      for (int f = 0; f < 16; f++) begin
        bit e;
        logic [3:0] fl;
        fl = f[3:0];
        e = expect_cond(k[3:0], fl[3], fl[2], fl[1], fl[0]);
        drive(k[3:0], fl, 32'hA5A5_0000 + k, 32'h5A5A_0000 + f);
        check(cond_true == e, req_of(k[3:0]), {31'd0, cond_true}, {31'd0, e});
      end
    end
  endtask

  task automatic t_invert_r3();
    for (int k = 0; k < 16; k += 2) begin
      for (int f = 0; f < 16; f++) begin
        logic r_even;
        logic [3:0] fl;
        fl = f[3:0];
        drive(k[3:0], fl, '0, '0);
        r_even = cond_true;
        drive(k[3:0] | 4'b0001, fl, '0, '0);
        check(cond_true == !r_even, "R3", {31'd0, cond_true}, {31'd0, !r_even});
      end
    end
  endtask

  task automatic t_select_r10();
    logic [DATA_W-1:0] pa [4] = '{32'hDEAD_BEEF, 32'h0000_0001, 32'hFFFF_FFFF, 32'h1234_5678};
    logic [DATA_W-1:0] pb [4] = '{32'h0BAD_F00D, 32'h8000_0000, 32'h0000_0000, 32'h8765_4321};
    for (int i = 0; i < 4; i++) begin
      drive(4'b0000, 4'h0, pa[i], pb[i]);
      check(sel_out == pa[i], "R10 true", sel_out, pa[i]);
      drive(4'b0111, 4'b0000, pa[i], pb[i]);
      check(sel_out == pb[i], "R10 false", sel_out, pb[i]);
    end
  endtask

  task automatic t_bool_r11();
    drive(4'b1011, 4'b0100, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check(bool_word == 32'h1, "R11 true", bool_word, 32'h1);
    drive(4'b1011, 4'b0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check(bool_word == 32'h0, "R11 false", bool_word, 32'h0);
  endtask

  task automatic t_hold_r2();
    drive(4'b0000, 4'h0, 32'h1111_1111, 32'h2222_2222);
    @(negedge clk);
    cond_code = 4'b0001;
    src_a = 32'h3333_3333;
    src_b = 32'h4444_4444;
    #1;
    check(cond_true == 1'b1, "R2 hold cond", {31'd0, cond_true}, 1);
    check(sel_out == 32'h1111_1111, "R2 hold sel", sel_out, 32'h1111_1111);
    @(posedge clk);
    #1;
    check(cond_true == 1'b0, "R2 update cond", {31'd0, cond_true}, 0);
    check(sel_out == 32'h4444_4444, "R2 update sel", sel_out, 32'h4444_4444);
  endtask

  initial begin
    t_reset_r1();
    t_sweep();
    t_invert_r3();
    t_select_r10();
    t_bool_r11();
    t_hold_r2();
    drive(4'b0000, 4'h0, 32'hCAFE_0000, 32'h0);
    t_reset_r1();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule